// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address by reading descriptors from a two-level translation table in memory. A client offers an address on a valid/ready handshake. The walker forms the first-level descriptor address from the table base input and the top twelve address bits, and issues one read. It then decodes the returned word. The descriptor either ends the walk (a 1 MB section or a fault) or points to a 256-entry second-level table, which costs a second read. The second-level word then yields a 64 KB large page, a 4 KB small page or a fault.

The memory side is a read port with a one-cycle request pulse, an address and a later valid strobe with the data word. Only one walk runs at a time. The result comes back as a one-cycle response carrying the physical address, the mapping size, a fault flag, the level at which the walk ended and the original virtual address. A large page occupies sixteen consecutive second-level slots that hold identical descriptors, so any of its sixteen 4 KB sub-ranges translates through the same descriptor.

Top module: `vatrans_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_rd_req` are 0. A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle after the response pulse.
- R2: The first read goes to the address {tbl_base[31:14], va[31:20], 2'b00}, using the table base present in the accepting cycle.
- R3: A first-level descriptor whose bits [1:0] are 0 or 3 ends the walk after one read with `rsp_fault`=1, `rsp_level`=0, `rsp_kind`=0 and `rsp_pa`=0.
- R4: A first-level descriptor with bits [1:0]=2 ends the walk after one read with `rsp_kind`=1 (section), `rsp_level`=0, `rsp_fault`=0 and `rsp_pa`={desc[31:20], va[19:0]}.
- R5: A first-level descriptor with bits [1:0]=1 causes exactly one more read, at the address {desc[31:10], va[19:12], 2'b00}.
- R6: A second-level descriptor with bits [1:0]=0 gives `rsp_fault`=1, `rsp_level`=1, `rsp_kind`=0 and `rsp_pa`=0.
- R7: A second-level descriptor with bits [1:0]=1 gives `rsp_kind`=2 (large page), `rsp_level`=1 and `rsp_pa`={desc[31:16], va[15:0]}. All sixteen slots of a large page translate the same way.
- R8: A second-level descriptor with bit 1 set (type 2 or 3) gives `rsp_kind`=3 (small page), `rsp_level`=1 and `rsp_pa`={desc[31:12], va[11:0]}.
- R9: `rsp_valid` is high for exactly one cycle per accepted request, and `rsp_va` equals the accepted virtual address, whatever the memory latency.
- R10: While a walk is running, `req_valid` has no effect: there is no extra read and no extra response. A `mem_rd_valid` pulse while no read is outstanding causes neither a response nor a read.
- R11: A change of `tbl_base` after a request is accepted does not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base | input | 32 | First-level table base, 16 KB aligned |
| req_valid | input | 1 | Translation request offered |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to take a request |
| mem_rd_req | output | 1 | One-cycle descriptor read request |
| mem_rd_addr | output | 32 | Descriptor word address (byte address, word aligned) |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_level | output | 1 | Level at which the walk ended: 0 first, 1 second |
| rsp_kind | output | 2 | 0 none, 1 section, 2 large page, 3 small page |
| rsp_va | output | 32 | Virtual address of this response |
| rsp_pa | output | 32 | Physical address, 0 on fault |

## Verification
On every cycle the checker ties each read address to the accepted address and the captured first-level pointer. It also checks that at most two reads are issued per walk, that the read count matches the level at which the walk ended, that the page offset bits carry through for each mapping size, and that responses and requests are single pulses. The upper physical bits taken from the descriptor, the fault encodings of both levels, the sixteen-slot large page, the base being held and the ignored requests and stray data strobes depend on table contents. Only the bench's directed scenarios, with a behavioural memory of known contents, can show those.

// File: rtl/vatrans_pkg.sv
package vatrans_pkg;

  // address field boundaries of the translation format
  localparam int unsigned WORD_LSB    = 2;
  localparam int unsigned SMALL_SHIFT = 12;
  localparam int unsigned LARGE_SHIFT = 16;
  localparam int unsigned SECT_SHIFT  = 20;
  localparam int unsigned L2_PTR_LSB  = 10;
  localparam int unsigned L1_TBL_LSB  = 14;

  localparam int unsigned L1_IDX_W = L1_TBL_LSB - WORD_LSB;
  localparam int unsigned L2_IDX_W = SECT_SHIFT - SMALL_SHIFT;

  // descriptor type codes in bits [1:0]
  localparam logic [1:0] L1_T_FAULT0 = 2'd0;
  localparam logic [1:0] L1_T_TABLE  = 2'd1;
  localparam logic [1:0] L1_T_SECT   = 2'd2;
  localparam logic [1:0] L2_T_FAULT  = 2'd0;
  localparam logic [1:0] L2_T_LARGE  = 2'd1;

  localparam logic LVL_FIRST  = 1'b0;
  localparam logic LVL_SECOND = 1'b1;

  typedef enum logic [1:0] {
    MAP_NONE    = 2'd0,
    MAP_SECTION = 2'd1,
    MAP_LARGE   = 2'd2,
    MAP_SMALL   = 2'd3
  } map_kind_e;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_L1   = 2'd1,
    WS_L2   = 2'd2,
    WS_RSP  = 2'd3
  } walk_state_e;

endpackage

// File: rtl/vatrans_l1_addr.sv
module vatrans_l1_addr
  import vatrans_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-L1_TBL_LSB-1:0] tbl_hi,
  input  logic [ADDR_W-SECT_SHIFT-1:0] l1_idx,
  output logic [ADDR_W-1:0]            l1_addr
);

  // 16 KB aligned table, one word per 1 MB region
  always_comb begin
    l1_addr = {tbl_hi, l1_idx, {WORD_LSB{1'b0}}};
  end

endmodule

// File: rtl/vatrans_l1_decode.sv
module vatrans_l1_decode
  import vatrans_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]     desc,
  input  logic [SECT_SHIFT-1:0] va_off,
  output logic                  is_fault,
  output logic                  is_table,
  output logic                  is_section,
  output logic [ADDR_W-1:0]     section_pa,
  output logic [ADDR_W-1:0]     l2_addr
);

  logic [1:0] dtype;
  logic       unused_desc_mid;

  assign dtype = desc[1:0];
  assign unused_desc_mid = ^desc[L2_PTR_LSB-1:WORD_LSB];

  always_comb begin
    is_table   = (dtype == L1_T_TABLE);
    is_section = (dtype == L1_T_SECT);
    // type 0 and type 3 are both treated as invalid
    is_fault   = !is_table && !is_section;
    section_pa = {desc[ADDR_W-1:SECT_SHIFT], va_off};
    l2_addr    = {desc[ADDR_W-1:L2_PTR_LSB],
                  va_off[SECT_SHIFT-1:SMALL_SHIFT],
                  {WORD_LSB{1'b0}}};
  end

endmodule

// File: rtl/vatrans_l2_decode.sv
module vatrans_l2_decode
  import vatrans_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]      desc,
  input  logic [LARGE_SHIFT-1:0] va_off,
  output logic                   is_fault,
  output logic [1:0]             kind,
  output logic [ADDR_W-1:0]      pa
);

  logic [1:0] dtype;
  logic       unused_desc_mid;

  assign dtype = desc[1:0];
  assign unused_desc_mid = ^desc[SMALL_SHIFT-1:WORD_LSB];

  always_comb begin
    is_fault = 1'b0;
    kind     = MAP_NONE;
    pa       = '0;
    if (dtype[1]) begin
      // small page: either encoding with bit 1 set
      kind = MAP_SMALL;
      pa   = {desc[ADDR_W-1:SMALL_SHIFT], va_off[SMALL_SHIFT-1:0]};
    end else if (dtype == L2_T_LARGE) begin
      kind = MAP_LARGE;
      pa   = {desc[ADDR_W-1:LARGE_SHIFT], va_off};
    end else begin
      is_fault = 1'b1;
    end
  end

endmodule

// File: rtl/vatrans_walker.sv
module vatrans_walker
  import vatrans_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_va,
  output logic              req_ready,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_level,
  output logic [1:0]        rsp_kind,
  output logic [ADDR_W-1:0] rsp_va,
  output logic [ADDR_W-1:0] rsp_pa
);

  walk_state_e       state_q;
  logic [ADDR_W-1:0] va_q;

  logic [ADDR_W-1:0] l1_rd_addr;
  logic              l1_fault;
  logic              l1_table;
  logic              l1_section;
  logic [ADDR_W-1:0] l1_section_pa;
  logic [ADDR_W-1:0] l2_rd_addr;
  logic              l2_fault;
  logic [1:0]        l2_kind;
  logic [ADDR_W-1:0] l2_pa;
  logic              unused_base_lo;

  assign unused_base_lo = ^tbl_base[L1_TBL_LSB-1:0];

  vatrans_l1_addr #(.ADDR_W(ADDR_W)) u_l1_addr (
    .tbl_hi  (tbl_base[ADDR_W-1:L1_TBL_LSB]),
    .l1_idx  (req_va[ADDR_W-1:SECT_SHIFT]),
    .l1_addr (l1_rd_addr)
  );

  vatrans_l1_decode #(.ADDR_W(ADDR_W)) u_l1_dec (
    .desc       (mem_rd_data),
    .va_off     (va_q[SECT_SHIFT-1:0]),
    .is_fault   (l1_fault),
    .is_table   (l1_table),
    .is_section (l1_section),
    .section_pa (l1_section_pa),
    .l2_addr    (l2_rd_addr)
  );

  vatrans_l2_decode #(.ADDR_W(ADDR_W)) u_l2_dec (
    .desc     (mem_rd_data),
    .va_off   (va_q[LARGE_SHIFT-1:0]),
    .is_fault (l2_fault),
    .kind     (l2_kind),
    .pa       (l2_pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= WS_IDLE;
      va_q        <= '0;
      req_ready   <= 1'b1;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_level   <= LVL_FIRST;
      rsp_kind    <= MAP_NONE;
      rsp_va      <= '0;
      rsp_pa      <= '0;
    end else begin
      mem_rd_req <= 1'b0;
      rsp_valid  <= 1'b0;
      case (state_q)
        WS_IDLE: begin
          if (req_valid) begin
            va_q        <= req_va;
            req_ready   <= 1'b0;
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= l1_rd_addr;
            state_q     <= WS_L1;
          end
        end
        WS_L1: begin
          if (mem_rd_valid) begin
            if (l1_table) begin
              mem_rd_req  <= 1'b1;
              mem_rd_addr <= l2_rd_addr;
              state_q     <= WS_L2;
            end else begin
              rsp_valid <= 1'b1;
              rsp_fault <= l1_fault;
              rsp_level <= LVL_FIRST;
              rsp_kind  <= l1_section ? MAP_SECTION : MAP_NONE;
              rsp_pa    <= l1_section ? l1_section_pa : '0;
              rsp_va    <= va_q;
              state_q   <= WS_RSP;
            end
          end
        end
        WS_L2: begin
          if (mem_rd_valid) begin
            rsp_valid <= 1'b1;
            rsp_fault <= l2_fault;
            rsp_level <= LVL_SECOND;
            rsp_kind  <= l2_kind;
            rsp_pa    <= l2_pa;
            rsp_va    <= va_q;
            state_q   <= WS_RSP;
          end
        end
        WS_RSP: begin
          req_ready <= 1'b1;
          state_q   <= WS_IDLE;
        end
        default: begin
          req_ready <= 1'b1;
          state_q   <= WS_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/vatrans_walker_chk.sv
module vatrans_walker_chk
  import vatrans_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_va,
  input logic [17:0] tbl_hi,
  input logic        mem_rd_req,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rd_valid,
  input logic [21:0] rd_ptr,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic        rsp_level,
  input logic [1:0]  rsp_kind,
  input logic [31:0] rsp_va,
  input logic [31:0] rsp_pa
);

  logic [31:0] acc_va;
  logic [17:0] acc_tbl;
  logic [21:0] l1_ptr_q;
  logic [1:0]  rd_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_va   <= '0;
      acc_tbl  <= '0;
      l1_ptr_q <= '0;
      rd_cnt   <= '0;
    end else begin
      if (req_valid && req_ready) begin
        acc_va  <= req_va;
        acc_tbl <= tbl_hi;
        rd_cnt  <= '0;
      end else if (mem_rd_req && rd_cnt != 2'd3) begin
        rd_cnt <= rd_cnt + 2'd1;
      end
      if (mem_rd_valid && !req_ready && rd_cnt == 2'd1)
        l1_ptr_q <= rd_ptr;
    end
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && mem_rd_req));

  p_busy_rsp_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  p_l1_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && rd_cnt == 2'd0) |-> (mem_rd_addr == {acc_tbl, acc_va[31:20], 2'b00}));

  p_fault_nopa_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_pa == 32'd0 && rsp_kind == MAP_NONE));

  p_first_end_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_level == LVL_FIRST) |-> (rd_cnt == 2'd1));

  p_section_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == MAP_SECTION) |->
      (rsp_level == LVL_FIRST && !rsp_fault && rsp_pa[19:0] == acc_va[19:0]));

  p_l2_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && rd_cnt == 2'd1) |-> (mem_rd_addr == {l1_ptr_q, acc_va[19:12], 2'b00}));

  p_l2_fault_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault && rsp_level == LVL_SECOND) |-> (rd_cnt == 2'd2));

  p_large_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == MAP_LARGE) |->
      (rsp_level == LVL_SECOND && rd_cnt == 2'd2 && rsp_pa[15:0] == acc_va[15:0]));

  p_small_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == MAP_SMALL) |->
      (rsp_level == LVL_SECOND && rd_cnt == 2'd2 && rsp_pa[11:0] == acc_va[11:0]));

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_rsp_va_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_va == acc_va));

  p_read_limit_r10: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> (rd_cnt < 2'd2 && !req_ready));

  p_read_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req);

endmodule

bind vatrans_walker vatrans_walker_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_va       (req_va),
  .tbl_hi       (tbl_base[31:14]),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rd_valid (mem_rd_valid),
  .rd_ptr       (mem_rd_data[31:10]),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_level    (rsp_level),
  .rsp_kind     (rsp_kind),
  .rsp_va       (rsp_va),
  .rsp_pa       (rsp_pa)
);

// File: tb/vatrans_walker_tb.sv
`timescale 1ns/1ps
module vatrans_walker_tb;

  localparam logic [31:0] BASE_A = 32'h8000_0000;
  localparam logic [31:0] BASE_B = 32'h4000_0000;
  localparam logic [31:0] L1_PTR = 32'h0010_0401;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tbl_base = BASE_A;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;
  logic        rsp_valid;
  logic        rsp_fault;
  logic        rsp_level;
  logic [1:0]  rsp_kind;
  logic [31:0] rsp_va;
  logic [31:0] rsp_pa;

  always #5 clk = ~clk;

  vatrans_walker u_dut (
    .clk (clk), .rst (rst), .tbl_base (tbl_base),
    .req_valid (req_valid), .req_va (req_va), .req_ready (req_ready),
    .mem_rd_req (mem_rd_req), .mem_rd_addr (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
    .rsp_valid (rsp_valid), .rsp_fault (rsp_fault), .rsp_level (rsp_level),
    .rsp_kind (rsp_kind), .rsp_va (rsp_va), .rsp_pa (rsp_pa)
  );

  // behavioural memory with programmable latency
  logic [31:0] mem [logic [31:0]];
  int          lat = 2;
  logic        model_valid = 1'b0;
  logic [31:0] model_data = '0;
  logic        stray_v = 1'b0;
  logic [31:0] stray_d = '0;
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [31:0] pend_addr = '0;
  int          rd_total = 0;
  int          rsp_total = 0;
  logic [31:0] hist [0:255];

  assign mem_rd_valid = model_valid | stray_v;
  assign mem_rd_data  = stray_v ? stray_d : model_data;

  always @(posedge clk) begin
    model_valid <= 1'b0;
    if (rst) begin
      pend <= 1'b0;
    end else if (mem_rd_req) begin
      pend      <= 1'b1;
      cnt       <= lat;
      pend_addr <= mem_rd_addr;
      hist[rd_total % 256] <= mem_rd_addr;
      rd_total  <= rd_total + 1;
    end else if (pend) begin
      if (cnt <= 1) begin
        model_valid <= 1'b1;
        model_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 32'd0;
        pend        <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rsp_valid) rsp_total <= rsp_total + 1;
  end

  int vectors = 0;
  int fails   = 0;

  function automatic logic [31:0] l1a(input logic [31:0] b, input logic [31:0] va);
    return {b[31:14], va[31:20], 2'b00};
  endfunction

  function automatic logic [31:0] l2a(input logic [31:0] d, input logic [31:0] va);
    return {d[31:10], va[19:12], 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // offer one request, wait for the response, check every field
  task automatic do_walk(input logic [31:0] va, input logic f, input logic lvl,
                         input logic [1:0] kind, input logic [31:0] pa,
                         input int nrd, input logic [31:0] l2addr, input string tag);
    int r0;
    int n;
    r0 = rd_total;
    n  = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_va    = va;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " response seen"}, {31'd0, rsp_valid}, 32'd1);
    chk({tag, " fault"}, {31'd0, rsp_fault}, {31'd0, f});
    chk({tag, " level"}, {31'd0, rsp_level}, {31'd0, lvl});
    chk({tag, " kind"}, {30'd0, rsp_kind}, {30'd0, kind});
    chk({tag, " pa"}, rsp_pa, pa);
    chk({tag, " R9 va echo"}, rsp_va, va);
    chk({tag, " read count"}, rd_total - r0, nrd);
    chk({tag, " R2 first read addr"}, hist[r0 % 256], l1a(BASE_A, va));
    if (nrd == 2) chk({tag, " R5 second read addr"}, hist[(r0 + 1) % 256], l2addr);
    @(negedge clk);
    chk({tag, " R9 pulse ends"}, {31'd0, rsp_valid}, 32'd0);
    chk({tag, " R1 ready again"}, {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 reset rd_req", {31'd0, mem_rd_req}, 32'd0);
  endtask

  task automatic t_section;
    do_walk(32'h1234_5678, 1'b0, 1'b0, 2'd1, 32'hABC4_5678, 1, 32'd0, "R4 section");
  endtask

  task automatic t_l1_fault;
    do_walk(32'h0230_0100, 1'b1, 1'b0, 2'd0, 32'd0, 1, 32'd0, "R3 l1 type0");
    do_walk(32'h0240_0000, 1'b1, 1'b0, 2'd0, 32'd0, 1, 32'd0, "R3 l1 type3");
  endtask

  task automatic t_small;
    do_walk(32'h0501_3ABC, 1'b0, 1'b1, 2'd3, 32'h7777_7ABC, 2,
            l2a(L1_PTR, 32'h0501_3ABC), "R8 small type2");
    do_walk(32'h0502_0FFF, 1'b0, 1'b1, 2'd3, 32'h6666_6FFF, 2,
            l2a(L1_PTR, 32'h0502_0FFF), "R8 small type3");
  endtask

  task automatic t_large;
    do_walk(32'h0504_0123, 1'b0, 1'b1, 2'd2, 32'h5550_0123, 2,
            l2a(L1_PTR, 32'h0504_0123), "R7 large first slot");
    do_walk(32'h0504_F456, 1'b0, 1'b1, 2'd2, 32'h5550_F456, 2,
            l2a(L1_PTR, 32'h0504_F456), "R7 large last slot");
  endtask

  task automatic t_l2_fault;
    do_walk(32'h0509_9000, 1'b1, 1'b1, 2'd0, 32'd0, 2,
            l2a(L1_PTR, 32'h0509_9000), "R6 l2 fault");
  endtask

  task automatic t_latency;
    lat = 1;
    do_walk(32'h1230_0001, 1'b0, 1'b0, 2'd1, 32'hABC0_0001, 1, 32'd0, "R9 short latency");
    lat = 7;
    do_walk(32'h0501_3000, 1'b0, 1'b1, 2'd3, 32'h7777_7000, 2,
            l2a(L1_PTR, 32'h0501_3000), "R9 long latency");
    lat = 2;
  endtask

  task automatic t_busy_ignored;
    int r0;
    int s0;
    int n;
    lat = 6;
    r0 = rd_total;
    s0 = rsp_total;
    n  = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_va    = 32'h1234_5678;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_va    = 32'h0230_0100;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R10 busy rsp va", rsp_va, 32'h1234_5678);
    chk("R10 busy rsp pa", rsp_pa, 32'hABC4_5678);
    repeat (10) @(negedge clk);
    chk("R10 busy single response", rsp_total - s0, 1);
    chk("R10 busy single read", rd_total - r0, 1);
    lat = 2;
  endtask

  task automatic t_stray;
    int r0;
    int s0;
    r0 = rd_total;
    s0 = rsp_total;
    @(negedge clk);
    stray_v = 1'b1;
    stray_d = 32'hDEAD_0002;
    @(negedge clk);
    stray_v = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 stray no response", rsp_total - s0, 0);
    chk("R10 stray no read", rd_total - r0, 0);
    chk("R10 stray still ready", {31'd0, req_ready}, 32'd1);
    do_walk(32'h0502_0FFF, 1'b0, 1'b1, 2'd3, 32'h6666_6FFF, 2,
            l2a(L1_PTR, 32'h0502_0FFF), "R10 walk after stray");
  endtask

  task automatic t_base_hold;
    int r0;
    int n;
    lat = 4;
    r0 = rd_total;
    n  = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_va    = 32'h0501_3ABC;
    @(negedge clk);
    req_valid = 1'b0;
    tbl_base  = BASE_B;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R11 base held pa", rsp_pa, 32'h7777_7ABC);
    chk("R11 base held kind", {30'd0, rsp_kind}, 32'd3);
    chk("R11 first read uses old base", hist[r0 % 256], l1a(BASE_A, 32'h0501_3ABC));
    @(negedge clk);
    tbl_base = BASE_A;
    lat = 2;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    mem[l1a(BASE_A, 32'h1234_5678)] = 32'hABC0_0002;
    mem[l1a(BASE_A, 32'h0240_0000)] = 32'hFFF0_0003;
    mem[l1a(BASE_A, 32'h0500_0000)] = L1_PTR;
    mem[l2a(L1_PTR, 32'h0501_3000)] = 32'h7777_7002;
    mem[l2a(L1_PTR, 32'h0502_0000)] = 32'h6666_6003;
    for (int i = 0; i < 16; i++)
      mem[l2a(L1_PTR, 32'h0504_0000 + (i << 12))] = 32'h5550_0001;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    t_reset();
    t_section();
    t_l1_fault();
    t_small();
    t_large();
    t_l2_fault();
    t_latency();
    t_busy_ignored();
    t_stray();
    t_base_hold();

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule